// File: doc/BRIEF.md
# Power-Domain Sequencer with Timed Wake

This block manages eight independently switchable power domains. Each domain is in one of three modes. In active mode its clock runs. In standby mode its clock is gated and the supply stays nominal. In sleep mode the clock is gated, the outputs are isolated, and the supply rail is dropped to a level at which the domain keeps its state. Because state survives sleep, a domain returns to operation without any save or reload step.

Software changes modes through a simple register write port. The block then steps each domain through an ordered sequence of clock-gate, isolation and rail-lowering controls. Leaving sleep reverses that order, and a programmable settle wait holds the domain between the rail rising and the isolation being released. A free-running timewheel is shared by all domains. Each domain can load one wake time, so it can sleep until the wheel reaches that value and then return to active mode by itself.

A read port selects one domain and returns its current mode and whether a transition is still under way.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: After synchronous reset every domain is active (clock enable 1, isolation 0, rail-low 0), its status reads 3'b000, and the settle register holds 3.
- R2: A write to address d (0..7) requests a mode for domain d from wr_data[1:0]: 0 = active, 1 = standby, 2 = sleep. The value 3 is ignored, and so is any write to an address from 17 to 31; neither changes any domain's outputs or status.
- R3: Standby gates the clock and keeps isolation off and the rail nominal. A change between active and standby appears on the outputs in the cycle after the edge that samples the write.
- R4: Entering sleep from active gates the clock at the first edge, asserts isolation at the second edge and lowers the rail at the third edge. From standby, isolation comes at the first edge and the rail drops at the second.
- R5: Leaving sleep raises the rail at the first edge. Isolation then stays on for settle+1 cycles before it is released, and the clock is re-enabled one edge later when the target is active. A write to address 16 loads the settle value from wr_data[3:0].
- R6: The timewheel reads 0 while reset is held and counts up by one per cycle, wrapping at 2^16. A write to address 8+d arms domain d's wake entry with wr_data. In the cycle where the wheel equals that entry, the domain's target becomes active and the entry is disarmed, so it fires only once.
- R7: If a timewheel wake and a mode write for the same domain fall in the same cycle, the wake wins and the domain's target becomes active.
- R8: rd_status for the domain selected by rd_dom is {busy, mode[1:0]}. The mode is active in the run state, standby while clock-gated with the rail nominal (including the isolation-on step of entry), and sleep while the rail is low or still settling. busy is 1 during the isolation and settle steps, or whenever the mode differs from the last requested mode.
- R9: A domain's clock is never enabled while its isolation is on or its rail is low. Isolation is always on while the rail is low.
- R10: Domains are independent: a request to one domain leaves the outputs of every other domain unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address: 0-7 mode, 8-15 wake time, 16 settle |
| wr_data | input | 16 | Write data |
| rd_dom | input | 3 | Domain selected for status read |
| rd_status | output | 3 | {busy, mode} of the selected domain |
| dom_clk_en | output | 8 | Per-domain clock enable |
| dom_iso | output | 8 | Per-domain output isolation |
| dom_rail_low | output | 8 | Per-domain rail-lowering enable |

## Verification
A sequencer that takes a wrong step shows up within one cycle on the clock, isolation and rail outputs. Examples are a clock re-enabled while isolation is still on, or a rail dropped before isolation. The bench therefore predicts each of these three outputs cycle by cycle for every transition. A stale target or settle count shows as a transition that ends a cycle early or late, or as a status read whose busy bit disagrees with the outputs. A wake entry that is never disarmed stays hidden until the wheel wraps, so the bench waits a full wheel period after a wake to catch a second firing.

// File: rtl/pdm_pkg.sv
`timescale 1ns/1ps
package pdm_pkg;

    typedef enum logic [1:0] {
        MODE_ACTIVE  = 2'd0,
        MODE_STANDBY = 2'd1,
        MODE_SLEEP   = 2'd2,
        MODE_RSVD    = 2'd3
    } pd_mode_e;

    typedef enum logic [2:0] {
        SEQ_RUN    = 3'd0,
        SEQ_HALT   = 3'd1,
        SEQ_CLAMP  = 3'd2,
        SEQ_RETAIN = 3'd3,
        SEQ_RAMP   = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        GRP_MODE = 2'd0,
        GRP_WAKE = 2'd1,
        GRP_CFG  = 2'd2,
        GRP_NONE = 2'd3
    } reg_grp_e;

    typedef struct packed {
        logic clk_en;
        logic iso;
        logic rail_low;
    } pd_ctrl_t;

    function automatic pd_ctrl_t ctrl_of(seq_state_e s);
        pd_ctrl_t c;
        case (s)
            SEQ_RUN:    c = '{clk_en: 1'b1, iso: 1'b0, rail_low: 1'b0};
            SEQ_HALT:   c = '{clk_en: 1'b0, iso: 1'b0, rail_low: 1'b0};
            SEQ_CLAMP:  c = '{clk_en: 1'b0, iso: 1'b1, rail_low: 1'b0};
            SEQ_RETAIN: c = '{clk_en: 1'b0, iso: 1'b1, rail_low: 1'b1};
            SEQ_RAMP:   c = '{clk_en: 1'b0, iso: 1'b1, rail_low: 1'b0};
            default:    c = '{clk_en: 1'b0, iso: 1'b1, rail_low: 1'b0};
        endcase
        return c;
    endfunction

    function automatic pd_mode_e mode_of(seq_state_e s);
        case (s)
            SEQ_RUN:             return MODE_ACTIVE;
            SEQ_HALT, SEQ_CLAMP: return MODE_STANDBY;
            default:             return MODE_SLEEP;
        endcase
    endfunction

    function automatic logic in_flight(seq_state_e s);
        return (s == SEQ_CLAMP) || (s == SEQ_RAMP);
    endfunction

endpackage

// File: rtl/pdm_timewheel.sv
`timescale 1ns/1ps
module pdm_timewheel #(
    parameter int N    = 8,
    parameter int TW_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0]          arm_we,
    input  logic [TW_W-1:0]       arm_time,
    output logic [N-1:0]          wake
);

    logic [TW_W-1:0]         tw_q;
    logic [N-1:0]            armed_q;
    logic [N-1:0][TW_W-1:0]  when_q;

    always_comb begin
        for (int d = 0; d < N; d++) begin
            wake[d] = armed_q[d] && (when_q[d] == tw_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tw_q    <= '0;
            armed_q <= '0;
            when_q  <= '0;
        end else begin
            tw_q <= tw_q + 1'b1;
            for (int d = 0; d < N; d++) begin
                if (arm_we[d]) begin
                    armed_q[d] <= 1'b1;
                    when_q[d]  <= arm_time;
                end else if (wake[d]) begin
                    armed_q[d] <= 1'b0;
                end
            end
        end
    end

    AST_TW_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> tw_q == TW_W'($past(tw_q) + 1'b1)) else $error("timewheel skipped"); // R6

    for (genvar g = 0; g < N; g++) begin : g_entry
        AST_WAKE_DISARMS: assert property (@(posedge clk) disable iff (rst)
            wake[g] && !arm_we[g] |=> !armed_q[g]) else $error("wake entry kept"); // R6
        AST_ARM_TAKES: assert property (@(posedge clk) disable iff (rst)
            arm_we[g] |=> armed_q[g] && when_q[g] == $past(arm_time)) else $error("arm lost"); // R6
    end

endmodule

// File: rtl/pdm_ctrl_regs.sv
`timescale 1ns/1ps
module pdm_ctrl_regs
    import pdm_pkg::*;
#(
    parameter int N          = 8,
    parameter int TW_W       = 16,
    parameter int SETTLE_W   = 4,
    parameter int SETTLE_RST = 3,
    localparam int DOM_W     = (N > 1) ? $clog2(N) : 1,
    localparam int ADDR_W    = DOM_W + 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [TW_W-1:0]       wr_data,
    input  logic [N-1:0]          wake,
    output logic [N-1:0]          arm_we,
    output logic [TW_W-1:0]       arm_time,
    output logic [N-1:0][1:0]     tgt_eff,
    output logic [N-1:0][1:0]     tgt_q,
    output logic [SETTLE_W-1:0]   settle_q
);

    reg_grp_e          grp;
    logic [DOM_W-1:0]  idx;
    logic              cfg_hit;
    logic [N-1:0]      mode_hit;

    assign grp      = reg_grp_e'(wr_addr[ADDR_W-1 -: 2]);
    assign idx      = wr_addr[DOM_W-1:0];
    assign cfg_hit  = wr_en && (grp == GRP_CFG) && (idx == '0);
    assign arm_time = wr_data;

    always_comb begin
        for (int d = 0; d < N; d++) begin
            mode_hit[d] = wr_en && (grp == GRP_MODE) && (idx == DOM_W'(d))
                          && (wr_data[1:0] != MODE_RSVD);
            arm_we[d]   = wr_en && (grp == GRP_WAKE) && (idx == DOM_W'(d));
            if (wake[d])          tgt_eff[d] = MODE_ACTIVE;
            else if (mode_hit[d]) tgt_eff[d] = wr_data[1:0];
            else                  tgt_eff[d] = tgt_q[d];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            settle_q <= SETTLE_W'(SETTLE_RST);
            for (int d = 0; d < N; d++) tgt_q[d] <= MODE_ACTIVE;
        end else begin
            if (cfg_hit) settle_q <= wr_data[SETTLE_W-1:0];
            for (int d = 0; d < N; d++) tgt_q[d] <= tgt_eff[d];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_WAKE_WINS: assert property (@(posedge clk) disable iff (rst)
            wake[g] |=> tgt_q[g] == MODE_ACTIVE) else $error("wake lost to write"); // R7
        AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (rst)
            wr_en && grp == GRP_MODE && idx == DOM_W'(g) && wr_data[1:0] == MODE_RSVD && !wake[g]
            |=> $stable(tgt_q[g])) else $error("reserved mode accepted"); // R2
    end

endmodule

// File: rtl/pdm_domain_seq.sv
`timescale 1ns/1ps
module pdm_domain_seq
    import pdm_pkg::*;
#(
    parameter int SETTLE_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           tgt_eff,
    input  logic [1:0]           tgt_q,
    input  logic [SETTLE_W-1:0]  settle,
    output pd_ctrl_t             ctrl,
    output logic [2:0]           status
);

    seq_state_e            state_q, state_d;
    logic [SETTLE_W-1:0]   cnt_q, cnt_d;
    pd_mode_e              tgt;
    logic                  busy;

    assign tgt = pd_mode_e'(tgt_eff);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            SEQ_RUN: begin
                if (tgt == MODE_STANDBY || tgt == MODE_SLEEP) state_d = SEQ_HALT;
            end
            SEQ_HALT: begin
                if (tgt == MODE_ACTIVE)     state_d = SEQ_RUN;
                else if (tgt == MODE_SLEEP) state_d = SEQ_CLAMP;
            end
            SEQ_CLAMP: begin
                state_d = (tgt == MODE_SLEEP) ? SEQ_RETAIN : SEQ_HALT;
            end
            SEQ_RETAIN: begin
                if (tgt != MODE_SLEEP) begin
                    state_d = SEQ_RAMP;
                    cnt_d   = settle;
                end
            end
            SEQ_RAMP: begin
                if (cnt_q == '0) state_d = SEQ_HALT;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = SEQ_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign ctrl   = ctrl_of(state_q);
    assign busy   = in_flight(state_q) || (mode_of(state_q) != pd_mode_e'(tgt_q));
    assign status = {busy, mode_of(state_q)};

    AST_GATE_BEFORE_ISO: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.iso) |-> !$past(ctrl.clk_en)) else $error("iso before gate"); // R4
    AST_ISO_BEFORE_RAIL: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.rail_low) |-> $past(ctrl.iso)) else $error("rail before iso"); // R4
    AST_ISO_HELD_ON_RAMP: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl.rail_low) |-> ctrl.iso) else $error("iso dropped with rail"); // R5
    AST_CLK_AFTER_ISO: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.clk_en) |-> !$past(ctrl.iso) && !$past(ctrl.rail_low)) else $error("clock early"); // R5
    AST_NO_CLK_IN_RETENTION: assert property (@(posedge clk) disable iff (rst)
        ctrl.rail_low |-> ctrl.iso && !ctrl.clk_en) else $error("retention unsafe"); // R9

endmodule

// File: rtl/pwr_domain_ctrl.sv
`timescale 1ns/1ps
module pwr_domain_ctrl
    import pdm_pkg::*;
#(
    parameter int N          = 8,
    parameter int TW_W       = 16,
    parameter int SETTLE_W   = 4,
    parameter int SETTLE_RST = 3,
    localparam int DOM_W     = (N > 1) ? $clog2(N) : 1,
    localparam int ADDR_W    = DOM_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [TW_W-1:0]    wr_data,
    input  logic [DOM_W-1:0]   rd_dom,
    output logic [2:0]         rd_status,
    output logic [N-1:0]       dom_clk_en,
    output logic [N-1:0]       dom_iso,
    output logic [N-1:0]       dom_rail_low
);

    logic [N-1:0]           wake;
    logic [N-1:0]           arm_we;
    logic [TW_W-1:0]        arm_time;
    logic [N-1:0][1:0]      tgt_eff;
    logic [N-1:0][1:0]      tgt_q;
    logic [SETTLE_W-1:0]    settle_q;
    logic [N-1:0][2:0]      status_all;

    pdm_timewheel #(.N(N), .TW_W(TW_W)) u_wheel (
        .clk      (clk),
        .rst      (rst),
        .arm_we   (arm_we),
        .arm_time (arm_time),
        .wake     (wake)
    );

    pdm_ctrl_regs #(
        .N(N), .TW_W(TW_W), .SETTLE_W(SETTLE_W), .SETTLE_RST(SETTLE_RST)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wake     (wake),
        .arm_we   (arm_we),
        .arm_time (arm_time),
        .tgt_eff  (tgt_eff),
        .tgt_q    (tgt_q),
        .settle_q (settle_q)
    );

    for (genvar g = 0; g < N; g++) begin : g_dom
        pd_ctrl_t ctrl;

        pdm_domain_seq #(.SETTLE_W(SETTLE_W)) u_seq (
            .clk     (clk),
            .rst     (rst),
            .tgt_eff (tgt_eff[g]),
            .tgt_q   (tgt_q[g]),
            .settle  (settle_q),
            .ctrl    (ctrl),
            .status  (status_all[g])
        );

        assign dom_clk_en[g]   = ctrl.clk_en;
        assign dom_iso[g]      = ctrl.iso;
        assign dom_rail_low[g] = ctrl.rail_low;
    end

    assign rd_status = status_all[rd_dom];

endmodule

// File: tb/pwr_domain_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_domain_ctrl_bench;

    localparam int N      = 8;
    localparam int TW_W   = 16;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [TW_W-1:0]   wr_data = '0;
    logic [2:0]        rd_dom = '0;
    logic [2:0]        rd_status;
    logic [N-1:0]      dom_clk_en, dom_iso, dom_rail_low;

    always #4 clk = ~clk;

    pwr_domain_ctrl u_pwr_domain_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_dom(rd_dom), .rd_status(rd_status), .dom_clk_en(dom_clk_en),
        .dom_iso(dom_iso), .dom_rail_low(dom_rail_low)
    );

    int cyc;
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        int         cy;
        int         dom;
        logic [2:0] ctl;
        string      req;
    } exp_t;

    exp_t sb[$];

    function automatic logic [2:0] ctl_of(int d);
        return {dom_clk_en[d], dom_iso[d], dom_rail_low[d]};
    endfunction

    task automatic push(int cy, int d, logic ce, logic iso, logic rl, string req);
        exp_t e;
        e.cy = cy; e.dom = d; e.ctl = {ce, iso, rl}; e.req = req;
        sb.push_back(e);
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    task automatic chk_status(int d, logic [2:0] exp, string req);
        rd_dom = 3'(d);
        #1;
        chk(req, int'(rd_status), int'(exp));
    endtask

    task automatic wr(int addr, int data, output int c);
        @(negedge clk);
        c       = cyc;
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(addr);
        wr_data = TW_W'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // monitor: pops expected control triples in the cycle they are due
    initial begin
        forever begin
            @(negedge clk);
            #1;
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].cy <= cyc) begin
                    n_chk++;
                    if (sb[i].cy != cyc || ctl_of(sb[i].dom) != sb[i].ctl) begin
                        n_fail++;
                        $display("FAIL %s dom%0d cycle %0d (due %0d): actual %b expected %b",
                                 sb[i].req, sb[i].dom, cyc, sb[i].cy, ctl_of(sb[i].dom), sb[i].ctl);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 140000) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual cycle %0d expected under 140000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int c, c2, t1, t2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int d = 0; d < N; d++) begin
            chk("R1", int'(ctl_of(d)), 3'b100);
            chk_status(d, 3'b000, "R1");
        end

        // R3: domain 0 active -> standby, R10: neighbour untouched
        wr(0, 1, c);
        push(c + 1, 0, 0, 0, 0, "R3");
        push(c + 1, 1, 1, 0, 0, "R10");

        // R4: domain 0 standby -> sleep
        wr(0, 2, c);
        push(c + 1, 0, 0, 1, 0, "R4");
        push(c + 2, 0, 0, 1, 1, "R4");

        // R4: domain 1 active -> sleep, R8 busy mid-way
        wr(1, 2, c);
        push(c + 1, 1, 0, 0, 0, "R4");
        push(c + 2, 1, 0, 1, 0, "R4");
        push(c + 3, 1, 0, 1, 1, "R4");
        push(c + 3, 2, 1, 0, 0, "R10");
        chk_status(1, 3'b101, "R8");

        // R2: reserved mode value and unmapped address ignored
        wr(2, 3, c);
        push(c + 1, 2, 1, 0, 0, "R2");
        wr(20, 1, c2);
        push(c2 + 1, 3, 1, 0, 0, "R2");
        push(c2 + 1, 4, 1, 0, 0, "R2");
        chk_status(2, 3'b000, "R2");

        // R5: domain 1 sleep -> active with default settle 3
        repeat (3) @(negedge clk);
        wr(1, 0, c);
        for (int k = 1; k <= 4; k++) push(c + k, 1, 0, 1, 0, "R5");
        push(c + 5, 1, 0, 0, 0, "R5");
        push(c + 6, 1, 1, 0, 0, "R5");
        @(negedge clk);
        chk_status(1, 3'b110, "R8");
        repeat (6) @(negedge clk);
        chk_status(1, 3'b000, "R8");

        // R5: settle 0, domain 0 sleep -> standby
        wr(16, 0, c);
        wr(0, 1, c2);
        push(c2 + 1, 0, 0, 1, 0, "R5");
        push(c2 + 2, 0, 0, 0, 0, "R5");
        push(c2 + 3, 0, 0, 0, 0, "R5");
        repeat (4) @(negedge clk);
        chk_status(0, 3'b001, "R8");

        // R6: domain 3 sleeps, timewheel wakes it
        wr(3, 2, c);
        t1 = cyc + 20;
        wr(11, t1, c);
        push(t1, 3, 0, 1, 1, "R6");
        push(t1 + 1, 3, 0, 1, 0, "R6");
        push(t1 + 2, 3, 0, 0, 0, "R6");
        push(t1 + 3, 3, 1, 0, 0, "R6");
        while (cyc < t1 + 5) @(negedge clk);
        chk_status(3, 3'b000, "R6");

        // R7: wake and standby write to domain 4 in the same cycle
        t2 = cyc + 10;
        wr(12, t2, c);
        while (cyc < t2 - 1) @(negedge clk);
        wr(4, 1, c);
        chk("R7", c, t2);
        push(c + 1, 4, 1, 0, 0, "R7");
        push(c + 2, 4, 1, 0, 0, "R7");
        repeat (2) @(negedge clk);
        chk_status(4, 3'b000, "R7");

        // R6: fired entry must not fire again after the wheel wraps
        wr(3, 2, c);
        while (cyc < t1 + 65536 + 6) @(negedge clk);
        chk("R6", int'(ctl_of(3)), 3'b011);

        repeat (5) @(negedge clk);
        chk("R6", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule